// File: doc/BRIEF.md
# Chained Descriptor Sample Mover

This block moves audio samples between the three internal memory spaces of a DSP (X, Y and P data) and a set of external sample buffers. Its work is described by a chain of seven-word command blocks kept in X data memory. Software writes the address of the first block into a head register and then issues a start write. The engine then runs without further help. For each block it reads all seven words, checks the control fields, and moves the requested number of samples one at a time. After each block it follows the block's link word to the next one.

Each sample takes two handshakes: a read on the source side, then a write of the same data on the destination side. The DSP side gets a memory space select and an address relative to the start of that space. The buffer side gets a byte address, the buffer identifier and the sample format code. The byte address advances by the byte width of the sample format. When the buffer is the circular one, the address wraps back to the buffer base.

A block whose link word has its end marker set ends the chain and raises a sticky end-of-chain flag. A block with an illegal encoding stops the engine and raises a sticky error flag instead.

Top module: `ll_dma_engine`

## Requirements
- R1: After a start write, the engine reads seven words from consecutive descriptor addresses, beginning at the head address. It holds `desc_req_o` and `desc_addr_o` steady until `desc_ack_i` is seen. The words are, in order: link, control, sample count, DSP address, buffer offset, buffer base and buffer limit.
- R2: Control bit 1 selects the direction. When it is 0, each sample is first read from the buffer (`buf_we_o`=0) and then written to DSP memory (`mem_we_o`=1) with the same data. When it is 1, each sample is read from DSP memory and then written to the buffer. The engine never requests both sides in the same cycle.
- R3: Each sample's DSP address is the descriptor's DSP address plus the sample index. Addresses 0x0000–0x17FF select space 0 (X) with the address unchanged. Addresses 0x1800–0x27FF select space 1 (Y), less 0x1800. Addresses 0x2800–0x37FF select space 2 (P), less 0x2800. The space is decoded again for every sample, so a run may cross from one space into the next.
- R4: The first buffer address is base plus offset. After each sample it advances by the byte width of the format in control bits 12:10: code 0 gives 1, code 1 gives 2, codes 2 and 6 give 3, and code 3 gives 4.
- R5: When control bits 8:5 equal 0xE (circular), an advanced buffer address greater than base plus limit is replaced by the base. Buffer codes 0x0–0x3 never wrap.
- R6: Every buffer request carries control bits 8:5 on `buf_id_o` and control bits 12:10 on `buf_fmt_o`.
- R7: A block with a sample count of 0 makes no memory or buffer request, and the engine goes on to the next block.
- R8: Link bits 13:0 give the address of the next block. Once the last sample of a block whose link bit 14 is set has been moved, `eol_o` becomes 1 and `busy_o` becomes 0.
- R9: A block is an error if any of these holds: its buffer code is not 0x0–0x3 or 0xE; its format code is 4, 5 or 7; or its count is nonzero and DSP address plus count exceeds 0x3800. On an error the engine makes no transfer for that block, sets `err_o`, leaves `eol_o` at 0 and goes idle.
- R10: A start write clears `eol_o` and `err_o`. Writes to the head register or the start command while `busy_o` is 1 have no effect.
- R11: After reset, and whenever `busy_o` is 0, the outputs `busy_o`, `eol_o`, `err_o` and all three request outputs are 0 (except for the sticky flags after a finished run).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control port write strobe |
| cfg_sel_i | input | 1 | 0: head address register, 1: start command |
| cfg_wdata_i | input | 24 | Control port write data |
| busy_o | output | 1 | Chain in progress |
| eol_o | output | 1 | Sticky end-of-chain flag |
| err_o | output | 1 | Sticky descriptor error flag |
| desc_req_o | output | 1 | Descriptor word read request |
| desc_addr_o | output | 14 | Descriptor word address in X memory |
| desc_ack_i | input | 1 | Descriptor read acknowledge, data valid |
| desc_rdata_i | input | 24 | Descriptor word |
| mem_req_o | output | 1 | DSP memory request |
| mem_we_o | output | 1 | DSP memory write enable |
| mem_space_o | output | 2 | DSP memory space: 0 X, 1 Y, 2 P |
| mem_addr_o | output | 13 | Address within the selected space |
| mem_wdata_o | output | 24 | DSP memory write data |
| mem_ack_i | input | 1 | DSP memory acknowledge |
| mem_rdata_i | input | 24 | DSP memory read data |
| buf_req_o | output | 1 | Buffer request |
| buf_we_o | output | 1 | Buffer write enable |
| buf_id_o | output | 4 | Buffer identifier |
| buf_fmt_o | output | 3 | Sample format code |
| buf_addr_o | output | 24 | Buffer byte address |
| buf_wdata_o | output | 24 | Buffer write data |
| buf_ack_i | input | 1 | Buffer acknowledge |
| buf_rdata_i | input | 24 | Buffer read data |

## Verification
The hardest behaviour to reach from the ports is a control write that lands while a chain is already running. To reach it, the bench issues a second head write and a second start right after a real start, while the first descriptors are still being fetched. It then restarts with no new head write, which shows at the descriptor port that the original head address was kept. A second hard case is a DSP address that crosses a space boundary in the middle of a block. The sweep places the run just below the Y and P space starts, so the space select changes partway through the run. The circular window is also kept small, so every sample width wraps at a different point.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  localparam int WORD_W   = 24;
  localparam int D_NEXT   = 0;
  localparam int D_CTRL   = 1;
  localparam int D_CNT    = 2;
  localparam int D_DSP    = 3;
  localparam int D_OFF    = 4;
  localparam int D_BASE   = 5;
  localparam int D_LIM    = 6;
  localparam int D_WORDS  = 7;
  localparam int EOL_BIT  = 14;
  localparam int DIR_BIT  = 1;
  localparam int BUF_LSB  = 5;
  localparam int BUF_W    = 4;
  localparam int FMT_LSB  = 10;
  localparam int FMT_W    = 3;
  localparam logic [15:0] Y_BASE  = 16'h1800;
  localparam logic [15:0] P_BASE  = 16'h2800;
  localparam logic [15:0] MAP_END = 16'h3800;
  localparam logic [3:0]  BUF_CIRC     = 4'hE;
  localparam logic [3:0]  BUF_FIFO_MAX = 4'h3;

  typedef enum logic [1:0] {SP_X = 2'd0, SP_Y = 2'd1, SP_P = 2'd2} space_e;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_RD, ST_WR, ST_NEXT} state_e;

  // byte width per format code, 0 marks an illegal code
  function automatic logic [2:0] fmt_step(input logic [FMT_W-1:0] f);
    case (f)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd4;
      3'd6:    return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ll_dma_desc_check.sv
module ll_dma_desc_check
  import ll_dma_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [DW-1:0]    ctrl_i,
  input  logic [DW-1:0]    cnt_i,
  input  logic [DW-1:0]    dsp_i,
  output logic             dir_o,
  output logic [BUF_W-1:0] buf_id_o,
  output logic [FMT_W-1:0] fmt_o,
  output logic             circ_o,
  output logic [2:0]       step_o,
  output logic             err_o
);
  logic [DW:0] span_end;
  logic        buf_bad, fmt_bad, range_bad;
  logic        unused_ctrl;

  assign dir_o    = ctrl_i[DIR_BIT];
  assign buf_id_o = ctrl_i[BUF_LSB +: BUF_W];
  assign fmt_o    = ctrl_i[FMT_LSB +: FMT_W];
  assign circ_o   = (buf_id_o == BUF_CIRC);
  assign step_o   = fmt_step(fmt_o);

  assign span_end  = {1'b0, dsp_i} + {1'b0, cnt_i};
  assign buf_bad   = !((buf_id_o <= BUF_FIFO_MAX) || circ_o);
  assign fmt_bad   = (step_o == 3'd0);
  assign range_bad = (cnt_i != '0) && (span_end > (DW+1)'(MAP_END));
  assign err_o     = buf_bad || fmt_bad || range_bad;

  assign unused_ctrl = ^{ctrl_i[DW-1:FMT_LSB+FMT_W], ctrl_i[FMT_LSB-1:BUF_LSB+BUF_W],
                         ctrl_i[BUF_LSB-1:DIR_BIT+1], ctrl_i[DIR_BIT-1:0]};
endmodule

// File: rtl/ll_dma_space_map.sv
module ll_dma_space_map
  import ll_dma_pkg::*;
#(
  parameter int DW  = WORD_W,
  parameter int LAW = 13
) (
  input  logic [DW-1:0]  addr_i,
  output space_e         space_o,
  output logic [LAW-1:0] local_o
);
  always_comb begin
    if (addr_i < DW'(Y_BASE)) begin
      space_o = SP_X;
      local_o = LAW'(addr_i);
    end else if (addr_i < DW'(P_BASE)) begin
      space_o = SP_Y;
      local_o = LAW'(addr_i - DW'(Y_BASE));
    end else begin
      space_o = SP_P;
      local_o = LAW'(addr_i - DW'(P_BASE));
    end
  end
endmodule

// File: rtl/ll_dma_buf_step.sv
module ll_dma_buf_step #(
  parameter int DW = 24
) (
  input  logic [DW-1:0] cur_i,
  input  logic [2:0]    step_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] limit_i,
  input  logic          circ_i,
  output logic [DW-1:0] nxt_o
);
  logic [DW-1:0] sum, top;
  assign sum   = cur_i + DW'(step_i);
  assign top   = base_i + limit_i;
  assign nxt_o = (circ_i && (sum > top)) ? base_i : sum;
endmodule

// File: rtl/ll_dma_engine.sv
module ll_dma_engine
  import ll_dma_pkg::*;
#(
  parameter int DW    = WORD_W,
  parameter int PTR_W = 14,
  parameter int LAW   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic             busy_o,
  output logic             eol_o,
  output logic             err_o,
  output logic             desc_req_o,
  output logic [PTR_W-1:0] desc_addr_o,
  input  logic             desc_ack_i,
  input  logic [DW-1:0]    desc_rdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [1:0]       mem_space_o,
  output logic [LAW-1:0]   mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             buf_req_o,
  output logic             buf_we_o,
  output logic [3:0]       buf_id_o,
  output logic [2:0]       buf_fmt_o,
  output logic [DW-1:0]    buf_addr_o,
  output logic [DW-1:0]    buf_wdata_o,
  input  logic             buf_ack_i,
  input  logic [DW-1:0]    buf_rdata_i
);
  localparam int IDX_W = $clog2(D_WORDS);

  state_e           state_q;
  logic [PTR_W-1:0] head_q, ptr_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    desc_q [D_WORDS];
  logic [DW-1:0]    cnt_q, dsp_q, bptr_q, data_q;
  logic             eol_q, err_q;

  logic             dir, circ, dec_err;
  logic [2:0]       step;
  logic [DW-1:0]    bptr_nxt;
  space_e           space;
  logic             rd_ph, wr_ph, src_ack, dst_ack;
  logic             unused_bits;

  ll_dma_desc_check #(.DW(DW)) u_check (
    .ctrl_i  (desc_q[D_CTRL]),
    .cnt_i   (desc_q[D_CNT]),
    .dsp_i   (desc_q[D_DSP]),
    .dir_o   (dir),
    .buf_id_o(buf_id_o),
    .fmt_o   (buf_fmt_o),
    .circ_o  (circ),
    .step_o  (step),
    .err_o   (dec_err)
  );

  ll_dma_space_map #(.DW(DW), .LAW(LAW)) u_map (
    .addr_i (dsp_q),
    .space_o(space),
    .local_o(mem_addr_o)
  );

  ll_dma_buf_step #(.DW(DW)) u_step (
    .cur_i  (bptr_q),
    .step_i (step),
    .base_i (desc_q[D_BASE]),
    .limit_i(desc_q[D_LIM]),
    .circ_i (circ),
    .nxt_o  (bptr_nxt)
  );

  assign rd_ph   = (state_q == ST_RD);
  assign wr_ph   = (state_q == ST_WR);
  assign src_ack = dir ? mem_ack_i : buf_ack_i;
  assign dst_ack = dir ? buf_ack_i : mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      dsp_q   <= '0;
      bptr_q  <= '0;
      data_q  <= '0;
      eol_q   <= 1'b0;
      err_q   <= 1'b0;
      for (int i = 0; i < D_WORDS; i++) desc_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cfg_we_i) begin
          if (!cfg_sel_i) head_q <= cfg_wdata_i[PTR_W-1:0];
          else begin
            ptr_q   <= head_q;
            idx_q   <= '0;
            eol_q   <= 1'b0;
            err_q   <= 1'b0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (desc_ack_i) begin
          desc_q[idx_q] <= desc_rdata_i;
          if (idx_q == IDX_W'(D_WORDS-1)) state_q <= ST_CHECK;
          else idx_q <= idx_q + 1'b1;
        end
        ST_CHECK: begin
          if (dec_err) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (desc_q[D_CNT] == '0) begin
            state_q <= ST_NEXT;
          end else begin
            cnt_q   <= desc_q[D_CNT];
            dsp_q   <= desc_q[D_DSP];
            bptr_q  <= desc_q[D_BASE] + desc_q[D_OFF];
            state_q <= ST_RD;
          end
        end
        ST_RD: if (src_ack) begin
          data_q  <= dir ? mem_rdata_i : buf_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (dst_ack) begin
          cnt_q   <= cnt_q - 1'b1;
          dsp_q   <= dsp_q + 1'b1;
          bptr_q  <= bptr_nxt;
          state_q <= (cnt_q == DW'(1)) ? ST_NEXT : ST_RD;
        end
        ST_NEXT: begin
          if (desc_q[D_NEXT][EOL_BIT]) begin
            eol_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ptr_q   <= desc_q[D_NEXT][PTR_W-1:0];
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign eol_o       = eol_q;
  assign err_o       = err_q;
  assign desc_req_o  = (state_q == ST_FETCH);
  assign desc_addr_o = ptr_q + PTR_W'(idx_q);
  assign mem_req_o   = dir ? rd_ph : wr_ph;
  assign mem_we_o    = !dir;
  assign mem_space_o = space;
  assign mem_wdata_o = data_q;
  assign buf_req_o   = dir ? wr_ph : rd_ph;
  assign buf_we_o    = dir;
  assign buf_addr_o  = bptr_q;
  assign buf_wdata_o = data_q;

  assign unused_bits = ^{desc_q[D_NEXT][DW-1:EOL_BIT+1], cfg_wdata_i[DW-1:PTR_W]};
endmodule

// File: rtl/ll_dma_engine_chk.sv
module ll_dma_engine_chk #(
  parameter int PTR_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             eol_o,
  input logic             err_o,
  input logic             desc_req_o,
  input logic             desc_ack_i,
  input logic [PTR_W-1:0] desc_addr_o,
  input logic             mem_req_o,
  input logic [1:0]       mem_space_o,
  input logic             buf_req_o
);
  // R9
  err_excl_eol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && eol_o));

  // R2
  one_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && buf_req_o));

  // R3
  space_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_space_o != 2'd3));

  // R1
  desc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o && !desc_ack_i) |=> (desc_req_o && $stable(desc_addr_o)));

  // R8
  eol_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eol_o) |-> !busy_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(desc_req_o || mem_req_o || buf_req_o));
endmodule

bind ll_dma_engine ll_dma_engine_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .eol_o      (eol_o),
  .err_o      (err_o),
  .desc_req_o (desc_req_o),
  .desc_ack_i (desc_ack_i),
  .desc_addr_o(desc_addr_o),
  .mem_req_o  (mem_req_o),
  .mem_space_o(mem_space_o),
  .buf_req_o  (buf_req_o)
);

// File: tb/tb_ll_dma_engine.sv
module tb_ll_dma_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [23:0] cfg_wdata_i = '0;
  logic        busy_o, eol_o, err_o;
  logic        desc_req_o, desc_ack_i;
  logic [13:0] desc_addr_o;
  logic [23:0] desc_rdata_i;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [1:0]  mem_space_o;
  logic [12:0] mem_addr_o;
  logic [23:0] mem_wdata_o, mem_rdata_i;
  logic        buf_req_o, buf_we_o, buf_ack_i;
  logic [3:0]  buf_id_o;
  logic [2:0]  buf_fmt_o;
  logic [23:0] buf_addr_o, buf_wdata_o, buf_rdata_i;

  always #10 clk = ~clk;

  ll_dma_engine dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .busy_o(busy_o), .eol_o(eol_o), .err_o(err_o),
    .desc_req_o(desc_req_o), .desc_addr_o(desc_addr_o),
    .desc_ack_i(desc_ack_i), .desc_rdata_i(desc_rdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_space_o(mem_space_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .buf_req_o(buf_req_o), .buf_we_o(buf_we_o), .buf_id_o(buf_id_o),
    .buf_fmt_o(buf_fmt_o), .buf_addr_o(buf_addr_o), .buf_wdata_o(buf_wdata_o),
    .buf_ack_i(buf_ack_i), .buf_rdata_i(buf_rdata_i)
  );

  int tests = 0, fails = 0;
  logic [23:0] xmem [64];
  int dn, mn, bn;
  logic [13:0] dlog [256];
  logic        mlog_we [64];
  logic [1:0]  mlog_sp [64];
  logic [12:0] mlog_addr [64];
  logic [23:0] mlog_data [64];
  logic        blog_we [64];
  logic [3:0]  blog_id [64];
  logic [2:0]  blog_fmt [64];
  logic [23:0] blog_addr [64];
  logic [23:0] blog_data [64];

  function automatic logic [23:0] bfn(input logic [23:0] a);
    return a ^ 24'hC3C3C3;
  endfunction
  function automatic logic [23:0] mfn(input logic [1:0] sp, input logic [12:0] a);
    return {sp, 9'h0, a} ^ 24'h5A0000;
  endfunction
  function automatic int ctrlw(input int dir, input int id, input int fmt);
    return (dir << 1) | (id << 5) | (fmt << 10);
  endfunction

  // responders: one-cycle ack pulse, logged at grant
  initial begin
    desc_ack_i = 0; mem_ack_i = 0; buf_ack_i = 0;
    desc_rdata_i = '0; mem_rdata_i = '0; buf_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        desc_ack_i = 0; mem_ack_i = 0; buf_ack_i = 0;
      end else begin
        if (desc_req_o && !desc_ack_i) begin
          desc_ack_i = 1;
          desc_rdata_i = xmem[desc_addr_o[5:0]];
          if (dn < 256) dlog[dn] = desc_addr_o;
          dn++;
        end else desc_ack_i = 0;
        if (mem_req_o && !mem_ack_i) begin
          mem_ack_i = 1;
          mem_rdata_i = mfn(mem_space_o, mem_addr_o);
          if (mn < 64) begin
            mlog_we[mn] = mem_we_o; mlog_sp[mn] = mem_space_o;
            mlog_addr[mn] = mem_addr_o; mlog_data[mn] = mem_wdata_o;
          end
          mn++;
        end else mem_ack_i = 0;
        if (buf_req_o && !buf_ack_i) begin
          buf_ack_i = 1;
          buf_rdata_i = bfn(buf_addr_o);
          if (bn < 64) begin
            blog_we[bn] = buf_we_o; blog_id[bn] = buf_id_o; blog_fmt[bn] = buf_fmt_o;
            blog_addr[bn] = buf_addr_o; blog_data[bn] = buf_wdata_o;
          end
          bn++;
        end else buf_ack_i = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic clear_logs();
    dn = 0; mn = 0; bn = 0;
  endtask

  task automatic cfg_write(input bit sel, input int data);
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = 24'(data);
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy_o, "R8 run did not finish", busy_o, 0);
  endtask

  task automatic put_desc(input int a, input int nxt, input int ctrl, input int cnt,
                          input int dsp, input int off, input int base, input int lim);
    xmem[a] = 24'(nxt); xmem[a+1] = 24'(ctrl); xmem[a+2] = 24'(cnt);
    xmem[a+3] = 24'(dsp); xmem[a+4] = 24'(off); xmem[a+5] = 24'(base);
    xmem[a+6] = 24'(lim);
  endtask

  task automatic run(input int head);
    clear_logs();
    cfg_write(0, head);
    cfg_write(1, 0);
    wait_idle();
  endtask

  task automatic verify_xfer(input int dir, input int id, input int fmt, input int cnt,
                             input int dsp, input int off, input int base, input int lim);
    int p, w, d, sp, la;
    w = (fmt == 0) ? 1 : (fmt == 1) ? 2 : (fmt == 3) ? 4 : 3;
    chk(mn == cnt, "R2 DSP side transfer count", mn, cnt);
    chk(bn == cnt, "R2 buffer side transfer count", bn, cnt);
    p = base + off;
    for (int i = 0; i < cnt && i < 64; i++) begin
      d = dsp + i;
      if (d < 'h1800) begin sp = 0; la = d; end
      else if (d < 'h2800) begin sp = 1; la = d - 'h1800; end
      else begin sp = 2; la = d - 'h2800; end
      chk(mlog_sp[i] == 2'(sp), "R3 memory space", mlog_sp[i], sp);
      chk(mlog_addr[i] == 13'(la), "R3 local address", mlog_addr[i], la);
      chk(blog_addr[i] == 24'(p), "R4 R5 buffer address", blog_addr[i], p);
      chk(blog_id[i] == 4'(id), "R6 buffer id", blog_id[i], id);
      chk(blog_fmt[i] == 3'(fmt), "R6 buffer format", blog_fmt[i], fmt);
      if (dir == 0) begin
        chk(blog_we[i] == 0 && mlog_we[i] == 1, "R2 buffer to DSP direction",
            {blog_we[i], mlog_we[i]}, 1);
        chk(mlog_data[i] == bfn(24'(p)), "R2 data to DSP", mlog_data[i], bfn(24'(p)));
      end else begin
        chk(blog_we[i] == 1 && mlog_we[i] == 0, "R2 DSP to buffer direction",
            {blog_we[i], mlog_we[i]}, 2);
        chk(blog_data[i] == mfn(2'(sp), 13'(la)), "R2 data to buffer", blog_data[i],
            mfn(2'(sp), 13'(la)));
      end
      p += w;
      if (id == 14 && p > base + lim) p = base;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int fl [5] = '{0, 1, 2, 3, 6};
    int dl [4] = '{'h0010, 'h17FE, 'h27FD, 'h3000};
    int k;
    for (int i = 0; i < 64; i++) xmem[i] = '0;
    clear_logs();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy_o && !eol_o && !err_o, "R11 reset flags", {busy_o, eol_o, err_o}, 0);
    chk(!desc_req_o && !mem_req_o && !buf_req_o, "R11 reset requests",
        {desc_req_o, mem_req_o, buf_req_o}, 0);

    // sweep: format x direction x buffer kind, DSP run crossing space borders
    k = 0;
    foreach (fl[f]) for (int dir = 0; dir < 2; dir++) for (int b = 0; b < 2; b++) begin
      int id;
      id = b ? 14 : 1;
      put_desc(0, 'h4000, ctrlw(dir, id, fl[f]), 5, dl[k % 4], 4, 'h100, 'hB);
      run(0);
      chk(dn == 7, "R1 descriptor words fetched", dn, 7);
      for (int j = 0; j < 7; j++) chk(dlog[j] == 14'(j), "R1 fetch order", dlog[j], j);
      chk(eol_o && !err_o, "R8 end of chain flag", {eol_o, err_o}, 2);
      verify_xfer(dir, id, fl[f], 5, dl[k % 4], 4, 'h100, 'hB);
      k++;
    end

    // chain A -> B (empty) -> C, with control writes during the run
    put_desc(8, 20, ctrlw(0, 0, 1), 2, 'h40, 0, 'h200, 'hFF);
    put_desc(20, 32, ctrlw(0, 2, 0), 0, 'h50, 0, 'h300, 'hF);
    put_desc(32, 'h4000, ctrlw(1, 2, 3), 1, 'h1900, 8, 'h400, 'hFF);
    clear_logs();
    cfg_write(0, 8);
    cfg_write(1, 0);
    cfg_write(0, 40);
    cfg_write(1, 0);
    wait_idle();
    chk(dn == 21, "R8 chained descriptor fetches", dn, 21);
    for (int j = 0; j < 7; j++) begin
      chk(dlog[j] == 14'(8 + j), "R8 first block addr", dlog[j], 8 + j);
      chk(dlog[7 + j] == 14'(20 + j), "R8 link to second block", dlog[7 + j], 20 + j);
      chk(dlog[14 + j] == 14'(32 + j), "R8 link to third block", dlog[14 + j], 32 + j);
    end
    chk(mn == 3 && bn == 3, "R7 empty block moves nothing", mn, 3);
    chk(mlog_sp[2] == 2'd1 && mlog_addr[2] == 13'h100, "R3 Y space in third block",
        mlog_addr[2], 'h100);
    chk(blog_addr[2] == 24'h408 && blog_we[2], "R2 third block writes buffer",
        blog_addr[2], 'h408);
    chk(eol_o, "R8 eol after chain", eol_o, 1);
    // restart with no head write: head must still be 8
    clear_logs();
    cfg_write(1, 0);
    wait_idle();
    chk(dn == 21 && dlog[0] == 14'd8, "R10 write while busy ignored", dlog[0], 8);

    // zero count alone
    put_desc(0, 'h4000, ctrlw(0, 3, 2), 0, 'h10, 0, 'h100, 'hF);
    run(0);
    chk(mn == 0 && bn == 0, "R7 zero count no transfer", mn + bn, 0);
    chk(eol_o && !err_o, "R7 zero count completes", {eol_o, err_o}, 2);

    // descriptor errors
    put_desc(0, 'h4000, ctrlw(0, 5, 0), 2, 'h10, 0, 'h100, 'hF);
    run(0);
    chk(err_o && !eol_o, "R9 bad buffer code", {err_o, eol_o}, 2);
    chk(mn == 0 && bn == 0, "R9 no transfer on bad buffer", mn + bn, 0);
    put_desc(0, 'h4000, ctrlw(1, 14, 5), 2, 'h10, 0, 'h100, 'hF);
    run(0);
    chk(err_o && !eol_o, "R9 bad format code", {err_o, eol_o}, 2);
    put_desc(0, 'h4000, ctrlw(1, 0, 4), 2, 'h10, 0, 'h100, 'hF);
    run(0);
    chk(err_o && !eol_o, "R9 format code 4", {err_o, eol_o}, 2);
    put_desc(0, 'h4000, ctrlw(0, 0, 1), 3, 'h37FE, 0, 'h100, 'hF);
    run(0);
    chk(err_o && !eol_o && mn == 0, "R9 DSP range overflow", {err_o, eol_o}, 2);
    // boundary: last P word is legal; this start also clears err
    put_desc(0, 'h4000, ctrlw(0, 0, 1), 2, 'h37FE, 0, 'h100, 'hF);
    run(0);
    chk(!err_o && eol_o, "R10 flags cleared by start", {err_o, eol_o}, 1);
    verify_xfer(0, 0, 1, 2, 'h37FE, 0, 'h100, 'hF);
    // error in second block after a good one
    put_desc(0, 8, ctrlw(1, 2, 0), 1, 'h20, 0, 'h100, 'hF);
    put_desc(8, 'h4000, ctrlw(1, 9, 0), 1, 'h20, 0, 'h100, 'hF);
    run(0);
    chk(err_o && !eol_o && mn == 1 && bn == 1, "R9 error in chained block",
        mn, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule